// File: doc/BRIEF.md
# Power-Management Event Window and SCI Controller

This block holds the power-management event registers of a system controller behind a relocatable 64-byte I/O window. Configuration logic elsewhere in the chip supplies a base-address dword and a control byte. The block claims I/O cycles that fall inside the window, but only while the control byte enables the window. The window holds a 16-bit event status register, a 16-bit event enable register, a 16-bit control register and a free-running timer that software can read.

Three hardware event inputs set status bits: a power button, a real-time-clock alarm and a global-lock release. The timer sets a fourth status bit each time its top bit toggles. Software clears status bits by writing ones to them. The system control interrupt (SCI) output is a level. It is high while any of the four event status bits is set together with its matching enable bit.

Top module: `pm_sci_ctrl`

## Requirements
- R1: After reset, the status, enable, control and timer registers all read 0, and `sci_o` is low.
- R2: The window base is bits 15:6 of `cfg_pmbase_i`. The low six bits and the upper half of that dword are ignored. A read at any byte address from base to base+63 asserts `io_claim_o`. A read at any address outside that range does not.
- R3: While `cfg_pmctl_i[0]` is 0, no access is claimed, `io_rdata_o` stays 0 and writes change no register.
- R4: Window layout. The dword at offset 0 carries status in bits 15:0 and enable in bits 31:16. The dword at offset 4 carries control in bits 15:0, and its bits 31:16 read 0. The dword at offset 8 carries the timer, zero-extended. Every other dword in the window reads 0. Byte enable k selects data bits 8k+7:8k. An unclaimed read returns 0.
- R5: In the cycle after an event input is high, its status bit reads 1. The power button sets bit 8, the RTC alarm sets bit 10 and the global lock sets bit 5. Status bits other than 0, 5, 8 and 10 always read 0.
- R6: Status bits clear when a 1 is written to them. Writing a 0 leaves a bit unchanged. If a bit is cleared and its event arrives in the same cycle, the bit stays set.
- R7: All 16 bits of the enable register can be written and read back.
- R8: `sci_o` is the OR, over bits 0, 5, 8 and 10, of status AND enable. It follows a register change in the next cycle. Enable bits in other positions have no effect on `sci_o`.
- R9: The timer is a TMR_W-bit counter, 24 bits by default. It advances by one on each clock edge at which `tmr_tick_i` is high, and it wraps to 0. Writes to its dword have no effect on it.
- R10: Timer status (bit 0) is set when the timer's top bit toggles, but only while enable bit 0 is 1. While enable bit 0 is 0, a toggle leaves status bit 0 at 0.
- R11: The control register holds 16 bits. Software writes it byte by byte and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pmbase_i | input | 32 | Configuration dword that holds the window base |
| cfg_pmctl_i | input | 8 | Configuration byte; bit 0 enables the window |
| io_addr_i | input | 16 | I/O byte address |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_be_i | input | 4 | Byte enables of the addressed dword |
| io_wdata_i | input | 32 | Write data |
| io_rdata_o | output | 32 | Read data; 0 when the read is not claimed |
| io_claim_o | output | 1 | The read is decoded by this window |
| tmr_tick_i | input | 1 | Timer advance enable |
| evt_pwrbtn_i | input | 1 | Power-button event |
| evt_rtc_i | input | 1 | RTC alarm event |
| evt_glock_i | input | 1 | Global-lock event |
| sci_o | output | 1 | Level system control interrupt |

## Verification
The assertions check the following on every cycle:
- a disabled window never claims, and unclaimed reads return zero;
- each power-button pulse leaves its status bit set;
- the timer steps exactly when ticked;
- timer status rises only on an armed toggle;
- a write of one clears status bit 8 when no event competes;
- the SCI is never high while all four source enables are clear.

Some behaviours only the bench scenarios can show. These are:
- window placement across two masked bases;
- the byte-lane layout;
- the per-bit SCI map swept over all 16 enable positions;
- the set-wins-over-clear collision;
- the timer's wrap count.

The bench runs the timer at six bits so that it toggles within a few dozen ticks.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned REG_W   = 16;

  // status/enable bit positions shared by both registers
  localparam int unsigned BIT_TMR = 0;
  localparam int unsigned BIT_GLK = 5;
  localparam int unsigned BIT_PWR = 8;
  localparam int unsigned BIT_RTC = 10;

  localparam logic [REG_W-1:0] SRC_MASK =
      (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GLK) |
      (REG_W'(1) << BIT_PWR) | (REG_W'(1) << BIT_RTC);

  // dword slots within the window
  localparam int unsigned SLOT_EVT = 0;
  localparam int unsigned SLOT_CTL = 1;
  localparam int unsigned SLOT_TMR = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EVT,
    SEL_CTL,
    SEL_TMR
  } pm_sel_e;
endpackage

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import pm_sci_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              win_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              rd_hit_o,
  output logic              wr_hit_o,
  output pm_sel_e           sel_o
);
  localparam int unsigned OFS_W  = $clog2(WIN_BYTES);
  localparam int unsigned SLOT_W = OFS_W - 2;

  logic              in_win;
  logic [SLOT_W-1:0] slot;
  logic [1:0]        unused_lsb;

  assign unused_lsb = addr_i[1:0];

  always_comb begin
    in_win   = win_en_i && (addr_i[ADDR_W-1:OFS_W] == base_i[ADDR_W-1:OFS_W]);
    slot     = addr_i[OFS_W-1:2];
    rd_hit_o = in_win && rd_i;
    wr_hit_o = in_win && wr_i;
    if (!in_win)                         sel_o = SEL_NONE;
    else if (slot == SLOT_W'(SLOT_EVT))  sel_o = SEL_EVT;
    else if (slot == SLOT_W'(SLOT_CTL))  sel_o = SEL_CTL;
    else if (slot == SLOT_W'(SLOT_TMR))  sel_o = SEL_TMR;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             msb_flip_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d      = tick_i ? cnt_q + TMR_W'(1) : cnt_q;
    msb_flip_o = tick_i && (&cnt_q[TMR_W-2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_sci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              evt_pwr_i,
  input  logic              evt_rtc_i,
  input  logic              evt_glk_i,
  input  logic              tmr_flip_i,
  output logic [REG_W-1:0]  sts_o,
  output logic [REG_W-1:0]  en_o,
  output logic              sci_o
);
  logic [REG_W-1:0] sts_q, sts_d, en_q, en_d;
  logic [REG_W-1:0] set_vec, clr_vec;
  logic             tmr_armed;

  always_comb begin
    tmr_armed = en_q[BIT_TMR] && !sts_q[BIT_TMR];
    set_vec   = '0;
    set_vec[BIT_TMR] = tmr_flip_i && tmr_armed;
    set_vec[BIT_GLK] = evt_glk_i;
    set_vec[BIT_PWR] = evt_pwr_i;
    set_vec[BIT_RTC] = evt_rtc_i;

    clr_vec = '0;
    if (wr_i) begin
      if (be_i[0]) clr_vec[7:0]  = wdata_i[7:0];
      if (be_i[1]) clr_vec[15:8] = wdata_i[15:8];
    end
    sts_d = ((sts_q & ~clr_vec) | set_vec) & SRC_MASK;

    en_d = en_q;
    if (wr_i) begin
      if (be_i[2]) en_d[7:0]  = wdata_i[23:16];
      if (be_i[3]) en_d[15:8] = wdata_i[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign sci_o = |(sts_q & en_q & SRC_MASK);
endmodule

// File: rtl/pm_sci_ctrl.sv
module pm_sci_ctrl
  import pm_sci_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 64,
  parameter int unsigned TMR_W     = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_pmbase_i,
  input  logic [7:0]  cfg_pmctl_i,
  input  logic [15:0] io_addr_i,
  input  logic        io_rd_i,
  input  logic        io_wr_i,
  input  logic [3:0]  io_be_i,
  input  logic [31:0] io_wdata_i,
  output logic [31:0] io_rdata_o,
  output logic        io_claim_o,
  input  logic        tmr_tick_i,
  input  logic        evt_pwrbtn_i,
  input  logic        evt_rtc_i,
  input  logic        evt_glock_i,
  output logic        sci_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              rd_hit, wr_hit;
  pm_sel_e           sel;
  logic              wr_evt, wr_ctl;
  logic [REG_W-1:0]  sts, en_r;
  logic [TMR_W-1:0]  tmr_cnt;
  logic              tmr_flip;
  logic [REG_W-1:0]  ctl_q, ctl_d;
  logic [DATA_W-1:0] tmr_ext, rd_mux;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_pmbase_i[31:ADDR_W], cfg_pmctl_i[7:1], io_wdata_i[31:16]};

  pm_io_decode #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES)
  ) u_dec (
    .base_i   (cfg_pmbase_i[ADDR_W-1:0]),
    .win_en_i (cfg_pmctl_i[0]),
    .addr_i   (io_addr_i[ADDR_W-1:0]),
    .rd_i     (io_rd_i),
    .wr_i     (io_wr_i),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit),
    .sel_o    (sel)
  );

  assign wr_evt = wr_hit && (sel == SEL_EVT);
  assign wr_ctl = wr_hit && (sel == SEL_CTL);

  pm_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tmr_tick_i),
    .cnt_o      (tmr_cnt),
    .msb_flip_o (tmr_flip)
  );

  pm_evt_regs u_evt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (wr_evt),
    .be_i       (io_be_i),
    .wdata_i    (io_wdata_i),
    .evt_pwr_i  (evt_pwrbtn_i),
    .evt_rtc_i  (evt_rtc_i),
    .evt_glk_i  (evt_glock_i),
    .tmr_flip_i (tmr_flip),
    .sts_o      (sts),
    .en_o       (en_r),
    .sci_o      (sci_o)
  );

  // control register next state
  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      if (io_be_i[0]) ctl_d[7:0]  = io_wdata_i[7:0];
      if (io_be_i[1]) ctl_d[15:8] = io_wdata_i[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctl_q <= '0;
    else             ctl_q <= ctl_d;
  end

  // read path
  always_comb begin
    tmr_ext = '0;
    tmr_ext[TMR_W-1:0] = tmr_cnt;
    unique case (sel)
      SEL_EVT: rd_mux = {en_r, sts};
      SEL_CTL: rd_mux = {{(DATA_W-REG_W){1'b0}}, ctl_q};
      SEL_TMR: rd_mux = tmr_ext;
      default: rd_mux = '0;
    endcase
    io_claim_o = rd_hit;
    io_rdata_o = rd_hit ? rd_mux : '0;
  end
endmodule

// File: rtl/pm_sci_ctrl_chk.sv
module pm_sci_ctrl_chk #(
  parameter int unsigned TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_en,
  input logic             claim,
  input logic [31:0]      rdata,
  input logic             evt_pwr,
  input logic             tick,
  input logic [TMR_W-1:0] cnt,
  input logic             flip,
  input logic [15:0]      sts,
  input logic [15:0]      en,
  input logic             wr_evt,
  input logic [3:0]       be,
  input logic [31:0]      wdata,
  input logic             sci
);
  assert_no_claim_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !claim);

  assert_rdata_zero_unclaimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |-> (rdata == 32'h0));

  assert_pwrbtn_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pwr |=> sts[8]);

  assert_timer_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == TMR_W'($past(cnt) + 1'b1)));

  assert_timer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_tmr_sts_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(flip && en[0]));

  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && be[1] && wdata[8] && !evt_pwr) |=> !sts[8]);

  assert_sci_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> ((en & 16'h0521) != 16'h0));
endmodule

bind pm_sci_ctrl pm_sci_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .win_en  (cfg_pmctl_i[0]),
  .claim   (io_claim_o),
  .rdata   (io_rdata_o),
  .evt_pwr (evt_pwrbtn_i),
  .tick    (tmr_tick_i),
  .cnt     (tmr_cnt),
  .flip    (tmr_flip),
  .sts     (sts),
  .en      (en_r),
  .wr_evt  (wr_evt),
  .be      (io_be_i),
  .wdata   (io_wdata_i),
  .sci     (sci_o)
);

// File: tb/pm_sci_ctrl_bench.sv
module pm_sci_ctrl_bench;
  localparam int TW = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_pmbase;
  logic [7:0]  cfg_pmctl;
  logic [15:0] io_addr;
  logic        io_rd, io_wr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic        io_claim;
  logic        tick, e_pwr, e_rtc, e_glk;
  logic        sci;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pm_sci_ctrl #(.TMR_W(TW)) u_pm_sci_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_pmbase_i(cfg_pmbase), .cfg_pmctl_i(cfg_pmctl),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr), .io_be_i(io_be),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_claim_o(io_claim),
    .tmr_tick_i(tick), .evt_pwrbtn_i(e_pwr), .evt_rtc_i(e_rtc),
    .evt_glock_i(e_glk), .sci_o(sci)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_be = 4'h0; io_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic c);
    io_addr = a; io_rd = 1'b1;
    #5;
    d = io_rdata; c = io_claim;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        c;
    logic [15:0] base, exp_sts;
    int          tcnt;

    rst_n = 1'b0; cfg_pmbase = 32'h0000_ABFF; cfg_pmctl = 8'h01;
    io_addr = '0; io_rd = 0; io_wr = 0; io_be = 0; io_wdata = 0;
    tick = 0; e_pwr = 0; e_rtc = 0; e_glk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = 16'hABC0;

    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      rd(base + 16'(4*s), d, c);
      chk(c && d == 0, "R1 reset reg", d, 0);
    end
    chk(sci == 1'b0, "R1 reset sci", {31'b0, sci}, 0);

    // R2 window sweep over two masked bases
    for (int b = 0; b < 2; b++) begin
      cfg_pmbase = (b == 0) ? 32'h0000_ABFF : 32'hFFFF_107F;
      base       = (b == 0) ? 16'hABC0 : 16'h1040;
      for (int o = -8; o < 72; o++) begin
        rd(16'(int'(base) + o), d, c);
        chk(c == (o >= 0 && o < 64), "R2 claim", {31'b0, c}, {31'b0, (o >= 0 && o < 64)});
      end
    end
    cfg_pmbase = 32'h0000_ABFF; base = 16'hABC0;

    // R11 control byte writes
    wr(base + 4, 4'b0011, 32'hFFFF_BEEF);
    rd(base + 4, d, c);
    chk(d == 32'h0000_BEEF, "R11 ctl write", d, 32'h0000_BEEF);
    wr(base + 4, 4'b0001, 32'h0000_0012);
    rd(base + 4, d, c);
    chk(d == 32'h0000_BE12, "R11 ctl low byte", d, 32'h0000_BE12);
    wr(base + 4, 4'b1100, 32'hFFFF_0000);
    rd(base + 4, d, c);
    chk(d == 32'h0000_BE12, "R4 ctl upper lanes", d, 32'h0000_BE12);
    // R4 spare slot reads zero
    rd(base + 12, d, c);
    chk(c && d == 0, "R4 spare slot", d, 0);

    // R3 disabled window: no claim, write ignored
    cfg_pmctl = 8'hFE;
    rd(base + 4, d, c);
    chk(!c && d == 0, "R3 disabled read", {c, d[30:0]}, 0);
    wr(base + 4, 4'b0011, 32'h0000_1111);
    cfg_pmctl = 8'h01;
    rd(base + 4, d, c);
    chk(d == 32'h0000_BE12, "R3 disabled write", d, 32'h0000_BE12);
    // R2 write just past the window is ignored
    wr(base + 68, 4'b0011, 32'h0000_2222);
    rd(base + 4, d, c);
    chk(d == 32'h0000_BE12, "R2 outside write", d, 32'h0000_BE12);

    // R7 enable register readback
    wr(base, 4'b1100, 32'hA5C3_0000);
    rd(base, d, c);
    chk(d[31:16] == 16'hA5C3, "R7 enable rw", {16'h0, d[31:16]}, 32'hA5C3);
    wr(base, 4'b1100, 32'h0);

    // R9 / R10 timer with enable bit 0 clear
    tcnt = 0;
    ticks(32); tcnt += 32;
    rd(base + 8, d, c);
    chk(d == 32'(tcnt % 64), "R9 timer count", d, 32'(tcnt % 64));
    chk(d[15:0] == 0 || d == 32'(tcnt % 64), "R9 timer", d, 32'(tcnt % 64));
    rd(base, d, c);
    chk(d[0] == 1'b0, "R10 unarmed toggle", d, 0);
    ticks(32); tcnt += 32;
    rd(base + 8, d, c);
    chk(d == 32'(tcnt % 64), "R9 timer wrap", d, 32'(tcnt % 64));
    wr(base + 8, 4'b1111, 32'hFFFF_FFFF);
    rd(base + 8, d, c);
    chk(d == 32'(tcnt % 64), "R9 timer write ignored", d, 32'(tcnt % 64));

    // R10 armed
    wr(base, 4'b0100, 32'h0001_0000);
    ticks(31); tcnt += 31;
    rd(base, d, c);
    chk(d[0] == 1'b0 && sci == 1'b0, "R10 before toggle", d, 32'h0001_0000);
    ticks(1); tcnt += 1;
    rd(base, d, c);
    chk(d[15:0] == 16'h0001, "R10 toggle sets", d, 32'h0001_0001);
    chk(sci == 1'b1, "R8 timer sci", {31'b0, sci}, 1);
    ticks(32); tcnt += 32;
    rd(base + 8, d, c);
    chk(d == 32'(tcnt % 64), "R9 timer after", d, 32'(tcnt % 64));
    wr(base, 4'b0001, 32'h0000_0001);
    rd(base, d, c);
    chk(d[0] == 1'b0 && sci == 1'b0, "R6 clear timer sts", d, 32'h0001_0000);

    // R5 events
    wr(base, 4'b1100, 32'h0100_0000);
    e_pwr = 1'b1;
    #5 chk(sci == 1'b0, "R8 sci before set", {31'b0, sci}, 0);
    @(negedge clk); e_pwr = 1'b0;
    chk(sci == 1'b1, "R8 sci next cycle", {31'b0, sci}, 1);
    rd(base, d, c);
    chk(d[15:0] == 16'h0100, "R5 pwrbtn bit8", d[15:0], 16'h0100);
    e_rtc = 1'b1; @(negedge clk); e_rtc = 1'b0;
    e_glk = 1'b1; @(negedge clk); e_glk = 1'b0;
    rd(base, d, c);
    chk(d[15:0] == 16'h0520, "R5 rtc+glock", d[15:0], 16'h0520);
    // R6 write zero no change, write one clears
    wr(base, 4'b0011, 32'h0000_0000);
    rd(base, d, c);
    chk(d[15:0] == 16'h0520, "R6 write zero", d[15:0], 16'h0520);
    wr(base, 4'b0010, 32'h0000_0100);
    rd(base, d, c);
    chk(d[15:0] == 16'h0420, "R6 w1c bit8", d[15:0], 16'h0420);
    // R6 set wins over clear
    e_rtc = 1'b1;
    wr(base, 4'b0011, 32'h0000_FFFF);
    e_rtc = 1'b0;
    rd(base, d, c);
    chk(d[15:0] == 16'h0400, "R6 set wins", d[15:0], 16'h0400);

    // R8 sweep: all four sources set, one enable bit at a time
    e_pwr = 1; e_glk = 1; @(negedge clk); e_pwr = 0; e_glk = 0;
    wr(base, 4'b1100, 32'h0001_0000);
    ticks(64); tcnt += 64;
    exp_sts = 16'h0521;
    rd(base, d, c);
    chk(d[15:0] == exp_sts, "R5 all sources", d[15:0], exp_sts);
    for (int i = 0; i < 16; i++) begin
      wr(base, 4'b1100, 32'(1) << (16 + i));
      chk(sci == exp_sts[i], "R8 enable bit sweep", {31'b0, sci}, {31'b0, exp_sts[i]});
    end
    wr(base, 4'b1100, 32'hFFFF_0000);
    for (int i = 0; i < 16; i++) begin
      if (exp_sts[i]) begin
        wr(base, 4'b0011, 32'(1) << i);
        exp_sts[i] = 1'b0;
        chk(sci == (exp_sts != 0), "R8 clear sweep", {31'b0, sci}, {31'b0, (exp_sts != 0)});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule